// File: doc/BRIEF.md
# Shared-Bus Microstepped Processor Core

This block is a small processor core whose registers all meet on one internal data bus. A step counter walks each instruction through a sequence of bus transfers, T0, T1 and onward. In every step the controller picks at most one source to drive the bus and raises the load enables of the registers that take the value. There are 32 general registers of 32 bits. Around them sit a program counter, an instruction register, a memory address register, a memory buffer register, an ALU input latch and an ALU output latch.

Instructions are fetched and executed from a word array inside the block. The array is reached only through the address and buffer registers. A loader port fills the array while the core is held in reset. Each instruction class takes its own number of steps, and the counter returns to T0 when a sequence ends. A halt instruction freezes the core. After that, a combinational debug port reads back any general register.

Top module: `ubus_core`

## Requirements
- R1: While reset is low and after it is released, `halted` is 0, `bus_conflict` is 0, all general registers read 0 and execution starts at byte address 0.
- R2: Every instruction starts with three fetch steps: address register from PC and output latch from PC+4, then buffer from memory and PC from the latch, then IR from the buffer. The word at byte address X is memory word X[7:2], and the next instruction follows at PC+4.
- R3: The instruction word holds the opcode in [31:27], ra in [26:22], rb in [21:17], rc in [16:12] and a 17-bit constant in [16:0]. Opcodes 1 to 4 (add, sub, and, or) write R[rb] op R[rc] into R[ra] and take 6 cycles in all.
- R4: Opcode 6 (immediate add) writes R[rb] plus the sign-extended 17-bit constant into R[ra], in 6 cycles, and reads R[rb] even when rb is 0.
- R5: Opcode 5 writes the bitwise complement of R[rb] into R[ra] and takes 5 cycles.
- R6: Opcodes 7 (load) and 8 (store) address memory at base plus the sign-extended constant, where base is R[rb]. A load writes the word into R[ra] and a store writes R[ra] into memory. Each takes 8 cycles.
- R7: For load and store, an rb field of 0 gives a base of zero whatever R[0] holds.
- R8: Opcode 9 loads PC from R[rb] when R[rc] equals 0 and otherwise falls through to PC+4. It takes 5 cycles.
- R9: No more than one bus source is enabled in any cycle, and `bus_conflict` stays 0.
- R10: Opcode 31 raises `halted` on the fourth cycle of its sequence and holds it there. It counts 4 cycles from its fetch. From then on no register, PC or memory word changes until reset.
- R11: `dbg_data` shows general register `dbg_addr` combinationally.
- R12: A cycle with `prog_we` high writes `prog_data` into memory word `prog_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_we | input | 1 | Memory loader write strobe |
| prog_addr | input | 6 | Memory loader word index |
| prog_data | input | 32 | Memory loader write data |
| dbg_addr | input | 5 | Debug register index |
| dbg_data | output | 32 | Debug register contents |
| halted | output | 1 | Core stopped on a halt instruction |
| bus_conflict | output | 1 | More than one bus source enabled this cycle |

## Verification
Most internal faults show up as a wrong `halted` time. A step counter that ends a sequence early or late, or that decodes the wrong class, moves the halt edge by a known number of cycles, so each class is timed alone against its exact count. Faults in the data path, such as a wrong source on the bus, a lost load enable or bad sign extension, leave a wrong value in a register or a wrong memory word. That value is read through the debug port once the program halts, or it steers a later load or branch so that it shows up there. A second bus driver raises `bus_conflict` in the cycle it occurs.

// File: rtl/ubus_pkg.sv
// Shared types for the shared-bus core: opcodes, ALU functions, bus
// source indices and the per-step control word.
package ubus_pkg;

    localparam logic [4:0] OP_ADD  = 5'd1;
    localparam logic [4:0] OP_SUB  = 5'd2;
    localparam logic [4:0] OP_AND  = 5'd3;
    localparam logic [4:0] OP_OR   = 5'd4;
    localparam logic [4:0] OP_NOT  = 5'd5;
    localparam logic [4:0] OP_ADDI = 5'd6;
    localparam logic [4:0] OP_LD   = 5'd7;
    localparam logic [4:0] OP_ST   = 5'd8;
    localparam logic [4:0] OP_BRZ  = 5'd9;
    localparam logic [4:0] OP_HALT = 5'd31;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_NOT, ALU_INC4
    } alu_op_e;

    typedef enum logic [1:0] {
        RSEL_RA, RSEL_RB, RSEL_RC
    } reg_sel_e;

    // Bus source indices, one drive enable each
    localparam int SRC_PC   = 0;
    localparam int SRC_C    = 1;
    localparam int SRC_MBR  = 2;
    localparam int SRC_REG  = 3;
    localparam int SRC_IMM  = 4;
    localparam int SRC_ZERO = 5;
    localparam int NSRC     = 6;

    typedef struct packed {
        logic [NSRC-1:0] drv;
        reg_sel_e        reg_sel;
        alu_op_e         alu_op;
        logic            ld_mar;
        logic            ld_mbr_bus;
        logic            ld_mbr_mem;
        logic            ld_pc;
        logic            ld_ir;
        logic            ld_a;
        logic            ld_c;
        logic            ld_con;
        logic            reg_we;
        logic            mem_we;
    } ctrl_t;

endpackage

// File: rtl/ubus_regfile.sv
// General register file: one bus-side read port selected by the controller,
// one write port fed from the bus, one debug read port.
// Assumes NREG is a power of two; all entries clear on reset.
module ubus_regfile #(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    localparam int RW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RW-1:0]   rd_addr,
    output logic [XLEN-1:0] rd_data,
    input  logic            we,
    input  logic [RW-1:0]   wr_addr,
    input  logic [XLEN-1:0] wr_data,
    input  logic [RW-1:0]   dbg_addr,
    output logic [XLEN-1:0] dbg_data
);
    logic [XLEN-1:0] regs [NREG];

    // Register storage with synchronous clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we) begin
            regs[wr_addr] <= wr_data;
        end
    end

    // Combinational read ports
    always_comb begin
        rd_data  = regs[rd_addr];
        dbg_data = regs[dbg_addr];
    end
endmodule

// File: rtl/ubus_alu.sv
// ALU between latch A and the bus. Assumes the controller selects one
// function per step; the result is captured by the output latch.
module ubus_alu import ubus_pkg::*; #(
    parameter int XLEN = 32
) (
    input  alu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y
);
    // Function select
    always_comb begin
        unique case (op)
            ALU_ADD:  y = a + b;
            ALU_SUB:  y = a - b;
            ALU_AND:  y = a & b;
            ALU_OR:   y = a | b;
            ALU_NOT:  y = ~b;
            ALU_INC4: y = b + XLEN'(4);
            default:  y = '0;
        endcase
    end
endmodule

// File: rtl/ubus_mem.sv
// Word memory behind the address/buffer registers, with a loader port.
// Assumes the loader is used only while the core is in reset; loader wins.
module ubus_mem #(
    parameter int XLEN  = 32,
    parameter int WORDS = 64,
    localparam int AW = $clog2(WORDS)
) (
    input  logic            clk,
    input  logic            prog_we,
    input  logic [AW-1:0]   prog_addr,
    input  logic [XLEN-1:0] prog_data,
    input  logic            we,
    input  logic [AW-1:0]   addr,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] rdata
);
    logic [XLEN-1:0] words [WORDS];

    // Write from loader or core
    always_ff @(posedge clk) begin
        if (prog_we)  words[prog_addr] <= prog_data;
        else if (we)  words[addr]      <= wdata;
    end

    // Read path, captured by the buffer register
    assign rdata = words[addr];
endmodule

// File: rtl/ubus_seq.sv
// Step generator and decoder. Walks T0..T7, returns to T0 at the end of
// each class's sequence, freezes on halt. Assumes IR is valid from T3 on.
module ubus_seq import ubus_pkg::*; (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [4:0] op,
    input  logic       rb_zero,
    input  logic       con,
    output ctrl_t      ctl,
    output logic [2:0] step,
    output logic       halted
);
    ctrl_t c;
    logic  last;
    logic  halt_set;

    function automatic alu_op_e alu_of(input logic [4:0] o);
        case (o)
            OP_SUB:  return ALU_SUB;
            OP_AND:  return ALU_AND;
            OP_OR:   return ALU_OR;
            default: return ALU_ADD;
        endcase
    endfunction

    // Decode one step into drive and load enables
    always_comb begin
        c        = '0;
        last     = 1'b0;
        halt_set = 1'b0;
        case (step)
            3'd0: begin
                c.drv[SRC_PC] = 1'b1; c.ld_mar = 1'b1;
                c.ld_c = 1'b1; c.alu_op = ALU_INC4;
            end
            3'd1: begin
                c.ld_mbr_mem = 1'b1; c.drv[SRC_C] = 1'b1; c.ld_pc = 1'b1;
            end
            3'd2: begin
                c.drv[SRC_MBR] = 1'b1; c.ld_ir = 1'b1;
            end
            3'd3: begin
                case (op)
                    OP_ADD, OP_SUB, OP_AND, OP_OR, OP_ADDI: begin
                        c.drv[SRC_REG] = 1'b1; c.reg_sel = RSEL_RB; c.ld_a = 1'b1;
                    end
                    OP_NOT: begin
                        c.drv[SRC_REG] = 1'b1; c.reg_sel = RSEL_RB;
                        c.alu_op = ALU_NOT; c.ld_c = 1'b1;
                    end
                    OP_LD, OP_ST: begin
                        if (rb_zero) c.drv[SRC_ZERO] = 1'b1;
                        else begin
                            c.drv[SRC_REG] = 1'b1; c.reg_sel = RSEL_RB;
                        end
                        c.ld_a = 1'b1;
                    end
                    OP_BRZ: begin
                        c.drv[SRC_REG] = 1'b1; c.reg_sel = RSEL_RC; c.ld_con = 1'b1;
                    end
                    OP_HALT: halt_set = 1'b1;
                    default: last = 1'b1;
                endcase
            end
            3'd4: begin
                case (op)
                    OP_ADD, OP_SUB, OP_AND, OP_OR: begin
                        c.drv[SRC_REG] = 1'b1; c.reg_sel = RSEL_RC;
                        c.alu_op = alu_of(op); c.ld_c = 1'b1;
                    end
                    OP_ADDI, OP_LD, OP_ST: begin
                        c.drv[SRC_IMM] = 1'b1; c.alu_op = ALU_ADD; c.ld_c = 1'b1;
                    end
                    OP_NOT: begin
                        c.drv[SRC_C] = 1'b1; c.reg_we = 1'b1; last = 1'b1;
                    end
                    OP_BRZ: begin
                        if (con) begin
                            c.drv[SRC_REG] = 1'b1; c.reg_sel = RSEL_RB; c.ld_pc = 1'b1;
                        end
                        last = 1'b1;
                    end
                    default: last = 1'b1;
                endcase
            end
            3'd5: begin
                case (op)
                    OP_ADD, OP_SUB, OP_AND, OP_OR, OP_ADDI: begin
                        c.drv[SRC_C] = 1'b1; c.reg_we = 1'b1; last = 1'b1;
                    end
                    OP_LD, OP_ST: begin
                        c.drv[SRC_C] = 1'b1; c.ld_mar = 1'b1;
                    end
                    default: last = 1'b1;
                endcase
            end
            3'd6: begin
                case (op)
                    OP_LD: c.ld_mbr_mem = 1'b1;
                    OP_ST: begin
                        c.drv[SRC_REG] = 1'b1; c.reg_sel = RSEL_RA; c.ld_mbr_bus = 1'b1;
                    end
                    default: last = 1'b1;
                endcase
            end
            default: begin
                if (op == OP_LD) begin
                    c.drv[SRC_MBR] = 1'b1; c.reg_we = 1'b1;
                end else if (op == OP_ST) begin
                    c.mem_we = 1'b1;
                end
                last = 1'b1;
            end
        endcase
    end

    // Gate all enables once halted
    assign ctl = halted ? ctrl_t'('0) : c;

    // Step counter and halt flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step   <= 3'd0;
            halted <= 1'b0;
        end else if (!halted) begin
            if (halt_set)  halted <= 1'b1;
            else if (last) step   <= 3'd0;
            else           step   <= step + 3'd1;
        end
    end
endmodule

// File: rtl/ubus_core.sv
// Shared-bus processor core top: architectural registers, bus multiplexer
// with one-hot drive enables, and the four sub-blocks.
// Assumes a 32-bit instruction word and 32 registers (5-bit fields).
module ubus_core import ubus_pkg::*; #(
    parameter int XLEN      = 32,
    parameter int NREG      = 32,
    parameter int MEM_WORDS = 64,
    localparam int AW = $clog2(MEM_WORDS),
    localparam int RW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            prog_we,
    input  logic [AW-1:0]   prog_addr,
    input  logic [XLEN-1:0] prog_data,
    input  logic [RW-1:0]   dbg_addr,
    output logic [XLEN-1:0] dbg_data,
    output logic            halted,
    output logic            bus_conflict
);
    localparam int KW = 17;

    logic [XLEN-1:0] pc_q, ir_q, mbr_q, a_q, c_q;
    logic [AW-1:0]   mar_q;
    logic            con_q;
    logic [XLEN-1:0] bus, alu_y, reg_rd, mem_rd, imm_sx;
    logic [XLEN-1:0] src [NSRC];
    logic [RW-1:0]   rd_sel;
    logic [2:0]      step;
    ctrl_t           ctl;

    assign imm_sx = {{(XLEN-KW){ir_q[KW-1]}}, ir_q[KW-1:0]};

    ubus_seq u_seq (
        .clk(clk), .rst_n(rst_n), .op(ir_q[31:27]),
        .rb_zero(ir_q[21:17] == '0), .con(con_q),
        .ctl(ctl), .step(step), .halted(halted)
    );

    // Register read address from the selected instruction field
    always_comb begin
        case (ctl.reg_sel)
            RSEL_RA: rd_sel = ir_q[26:22];
            RSEL_RB: rd_sel = ir_q[21:17];
            default: rd_sel = ir_q[16:12];
        endcase
    end

    ubus_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
        .clk(clk), .rst_n(rst_n), .rd_addr(rd_sel), .rd_data(reg_rd),
        .we(ctl.reg_we), .wr_addr(ir_q[26:22]), .wr_data(bus),
        .dbg_addr(dbg_addr), .dbg_data(dbg_data)
    );

    ubus_alu #(.XLEN(XLEN)) u_alu (
        .op(ctl.alu_op), .a(a_q), .b(bus), .y(alu_y)
    );

    ubus_mem #(.XLEN(XLEN), .WORDS(MEM_WORDS)) u_mem (
        .clk(clk), .prog_we(prog_we), .prog_addr(prog_addr),
        .prog_data(prog_data), .we(ctl.mem_we), .addr(mar_q),
        .wdata(mbr_q), .rdata(mem_rd)
    );

    // Bus sources in index order
    always_comb begin
        src[SRC_PC]   = pc_q;
        src[SRC_C]    = c_q;
        src[SRC_MBR]  = mbr_q;
        src[SRC_REG]  = reg_rd;
        src[SRC_IMM]  = imm_sx;
        src[SRC_ZERO] = '0;
    end

    // Bus multiplexer: OR of enabled sources
    always_comb begin
        bus = '0;
        for (int i = 0; i < NSRC; i++)
            if (ctl.drv[i]) bus = bus | src[i];
    end

    assign bus_conflict = ($countones(ctl.drv) > 1);

    // Architectural registers with load enables
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= '0;
            ir_q  <= '0;
            mbr_q <= '0;
            a_q   <= '0;
            c_q   <= '0;
            mar_q <= '0;
            con_q <= 1'b0;
        end else begin
            if (ctl.ld_pc)      pc_q  <= bus;
            if (ctl.ld_ir)      ir_q  <= bus;
            if (ctl.ld_a)       a_q   <= bus;
            if (ctl.ld_c)       c_q   <= alu_y;
            if (ctl.ld_mar)     mar_q <= bus[AW+1:2];
            if (ctl.ld_con)     con_q <= (bus == '0);
            if (ctl.ld_mbr_mem) mbr_q <= mem_rd;
            else if (ctl.ld_mbr_bus) mbr_q <= bus;
        end
    end
endmodule

// File: rtl/ubus_core_chk.sv
// Property checker for ubus_core, attached by bind below.
module ubus_core_chk import ubus_pkg::*; #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] drv,
    input logic            bus_conflict,
    input logic            halted,
    input logic [XLEN-1:0] pc,
    input logic [2:0]      step
);
    a_r9_onehot_drive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(drv));

    a_r9_no_conflict: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_conflict);

    a_r10_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    a_r10_pc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(pc));

    a_r2_fetch_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (step == 3'd0 && !halted) |=> (step == 3'd1));

    a_r6_step_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step == 3'd7) |=> (step == 3'd0));
endmodule

bind ubus_core ubus_core_chk #(.XLEN(XLEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .drv(ctl.drv), .bus_conflict(bus_conflict),
    .halted(halted), .pc(pc_q), .step(step)
);

// File: tb/ubus_core_bench.sv
// Directed bench for ubus_core: one task per scenario.
module ubus_core_bench;
    localparam logic [4:0] K_ADD = 1, K_SUB = 2, K_AND = 3, K_OR = 4, K_NOT = 5,
                           K_ADDI = 6, K_LD = 7, K_ST = 8, K_BRZ = 9, K_HALT = 31;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_we = 1'b0;
    logic [5:0]  prog_addr = '0;
    logic [31:0] prog_data = '0;
    logic [4:0]  dbg_addr = '0;
    logic [31:0] dbg_data;
    logic        halted, bus_conflict;

    int n_chk = 0, n_bad = 0, n_conf = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ubus_core u_ubus_core (
        .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
        .prog_data(prog_data), .dbg_addr(dbg_addr), .dbg_data(dbg_data),
        .halted(halted), .bus_conflict(bus_conflict)
    );

    always @(negedge clk) if (rst_n && bus_conflict) n_conf++;

    function automatic logic [31:0] enc(logic [4:0] op, logic [4:0] ra,
                                        logic [4:0] rb, logic [4:0] rc,
                                        logic [16:0] k);
        return {op, ra, rb, (k | {rc, 12'b0})};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic hold_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic put(int idx, logic [31:0] w);
        @(negedge clk);
        prog_we = 1'b1; prog_addr = idx[5:0]; prog_data = w;
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    // Release reset and count rising edges until halted
    task automatic run(output int cyc);
        cyc = 0;
        @(negedge clk);
        rst_n = 1'b1;
        while (!halted && cyc < 2000) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic rd(int r, output logic [31:0] v);
        dbg_addr = r[4:0];
        #1;
        v = dbg_data;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        hold_reset();
        chk("R1 halted in reset", {31'b0, halted}, 32'd0);
        chk("R1 conflict in reset", {31'b0, bus_conflict}, 32'd0);
        rd(5, v);
        chk("R1 reg clear", v, 32'd0);
    endtask

    task automatic t_arith();
        logic [31:0] v, a, b;
        int cyc;
        a = 32'd100; b = 32'hFFFF_FFF9;
        hold_reset();
        put(0, enc(K_ADDI, 1, 0, 0, 17'd100));
        put(1, enc(K_ADDI, 2, 0, 0, 17'h1FFF9));
        put(2, enc(K_ADD, 3, 1, 2, 0));
        put(3, enc(K_SUB, 4, 1, 2, 0));
        put(4, enc(K_AND, 5, 1, 2, 0));
        put(5, enc(K_OR, 6, 1, 2, 0));
        put(6, enc(K_NOT, 7, 1, 0, 0));
        put(7, enc(K_HALT, 0, 0, 0, 0));
        run(cyc);
        chk("R10 halted", {31'b0, halted}, 32'd1);
        rd(2, v); chk("R4 negative immediate", v, b);
        rd(3, v); chk("R3 add", v, a + b);
        rd(4, v); chk("R3 sub", v, a - b);
        rd(5, v); chk("R3 and", v, a & b);
        rd(6, v); chk("R3 or", v, a | b);
        rd(7, v); chk("R5 not", v, ~a);
        chk("R2 total cycles", cyc, 6*6 + 5 + 4);
        repeat (20) @(negedge clk);
        chk("R10 still halted", {31'b0, halted}, 32'd1);
        rd(3, v); chk("R10 reg frozen", v, a + b);
        rd(7, v); chk("R11 debug read", v, ~a);
    endtask

    task automatic t_mem();
        logic [31:0] v;
        int cyc;
        hold_reset();
        put(52, 32'h0000_ABCD);
        put(0, enc(K_ADDI, 1, 0, 0, 17'h55));
        put(1, enc(K_ST, 1, 0, 0, 17'd200));
        put(2, enc(K_LD, 2, 0, 0, 17'd200));
        put(3, enc(K_ADDI, 3, 0, 0, 17'd196));
        put(4, enc(K_LD, 4, 3, 0, 17'd4));
        put(5, enc(K_ADDI, 0, 0, 0, 17'd8));
        put(6, enc(K_LD, 5, 0, 0, 17'd200));
        put(7, enc(K_ADDI, 6, 0, 0, 17'h1FFFD));
        put(8, enc(K_LD, 9, 3, 0, 17'd12));
        put(9, enc(K_ST, 6, 3, 0, 17'd12));
        put(10, enc(K_LD, 7, 3, 0, 17'd12));
        put(11, enc(K_LD, 8, 3, 0, 17'h1FF3C));
        put(12, enc(K_HALT, 0, 0, 0, 0));
        run(cyc);
        chk("R6 halted", {31'b0, halted}, 32'd1);
        rd(2, v); chk("R6 store then load", v, 32'h55);
        rd(4, v); chk("R6 base plus disp", v, 32'h55);
        rd(5, v); chk("R7 rb zero base", v, 32'h55);
        rd(6, v); chk("R4 rb zero reads R0", v, 32'd5);
        rd(9, v); chk("R12 preloaded word", v, 32'h0000_ABCD);
        rd(7, v); chk("R6 store via base", v, 32'd5);
        rd(8, v); chk("R6 negative disp", v, enc(K_ADDI, 1, 0, 0, 17'h55));
    endtask

    task automatic t_branch();
        logic [31:0] v;
        int cyc;
        hold_reset();
        put(0, enc(K_ADDI, 1, 0, 0, 17'd16));
        put(1, enc(K_BRZ, 0, 1, 2, 0));
        put(2, enc(K_ADDI, 3, 0, 0, 17'd1));
        put(3, enc(K_HALT, 0, 0, 0, 0));
        put(4, enc(K_ADDI, 4, 0, 0, 17'd2));
        put(5, enc(K_ADDI, 5, 0, 0, 17'd5));
        put(6, enc(K_BRZ, 0, 1, 5, 0));
        put(7, enc(K_ADDI, 6, 0, 0, 17'd3));
        put(8, enc(K_HALT, 0, 0, 0, 0));
        run(cyc);
        chk("R8 halted", {31'b0, halted}, 32'd1);
        rd(3, v); chk("R8 taken skips", v, 32'd0);
        rd(4, v); chk("R8 target runs", v, 32'd2);
        rd(6, v); chk("R8 not taken falls through", v, 32'd3);
        chk("R8 cycles", cyc, 4*6 + 2*5 + 4);
    endtask

    task automatic t_timing(logic [31:0] w, int exp, string req);
        int cyc;
        hold_reset();
        put(0, w);
        put(1, enc(K_HALT, 0, 0, 0, 0));
        run(cyc);
        chk(req, cyc, exp);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_up();
    end

    initial begin
        t_reset();
        t_arith();
        t_mem();
        t_branch();
        t_timing(enc(K_ADD, 1, 2, 3, 0), 10, "R3 add timing");
        t_timing(enc(K_NOT, 1, 2, 0, 0), 9, "R5 not timing");
        t_timing(enc(K_LD, 1, 0, 0, 17'd4), 12, "R6 load timing");
        t_timing(enc(K_ST, 1, 0, 0, 17'd100), 12, "R6 store timing");
        t_timing(enc(K_HALT, 0, 0, 0, 0), 4, "R10 halt timing");
        chk("R9 bus conflicts", n_conf, 0);
        finish_up();
    end
endmodule